// File: doc/BRIEF.md
# PWM Bridge Steering Unit

The block produces one pulse-width-modulated waveform from a free-running period counter and a 10-bit duty value, then routes it onto four drive pins, A, B, C and D. A 2-bit steering code picks one of four pin arrangements: one modulated pin, a complementary half-bridge pair, or a full bridge driven forward or in reverse. Two polarity bits set the active level of the A/C pair and of the B/D pair independently. In half-bridge operation, a programmable dead-band delay holds back each rising transition so that the two complementary pins never drive at the same time.

Software writes a control byte that holds the steering code, the two low duty bits and a 4-bit mode, and a separate byte that holds the upper eight duty bits. The period and the dead-band count are plain inputs. Each pin has an enable output that tells the pad whether the unit is driving it or has released it for other use.

Top module: `epwm_steer`

## Requirements
- R1: A control write stores ctl_wdata[7:6] as the steering code, ctl_wdata[5:4] as the two low duty bits and ctl_wdata[3:0] as the mode. A duty write stores duty_wdata as the upper eight duty bits, so the duty is upper*4 + low.
- R2: Only modes of the form 11xx run the PWM. Any other mode, including 0000, releases all four pins and holds the counter and the dead-band state at zero. When the PWM is enabled, the counter starts from 0 in the first cycle after the enabling write.
- R3: The counter runs from 0 to period and then wraps to 0, so each PWM period lasts period+1 cycles. The modulated signal is active while count < duty. A duty of 0 keeps it inactive for the whole period. A duty greater than period keeps it active for the whole period.
- R4: A new duty value takes effect only at the wrap of the counter, or when the PWM is enabled. A write in the middle of a period leaves the current period unchanged.
- R5: Steering 00: only A is enabled and modulated. B, C and D are released.
- R6: Steering 01 (full-bridge forward): all four pins are enabled. D is modulated, A is held active, and B and C are held inactive.
- R7: Steering 10 (half-bridge): A carries the modulated signal and B carries its complement, each with dead-band applied. C and D are released.
- R8: Steering 11 (full-bridge reverse): all four pins are enabled. B is modulated, C is held active, and A and D are held inactive.
- R9: Mode bit 1 set makes A and C active-low. Mode bit 0 set makes B and D active-low. With the bit clear, the pair is active-high.
- R10: A released pin drives out=0 with enable=0. pwm_out and pwm_oe use bit 0 for A, bit 1 for B, bit 2 for C and bit 3 for D.
- R11: In half-bridge operation, a pin becomes active only after its source has been active for dead_cnt consecutive cycles, and it goes inactive in the same cycle its source does. A and B are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Steering code, low duty bits and mode |
| duty_we | input | 1 | Upper duty write strobe |
| duty_wdata | input | 8 | Upper eight duty bits |
| period | input | 10 | Last count value of the period |
| dead_cnt | input | 7 | Dead-band delay in clocks |
| pwm_out | output | 4 | Pin levels, bit 0 = A through bit 3 = D |
| pwm_oe | output | 4 | Pin drive enables, bit 0 = A through bit 3 = D |

## Verification
A fault in the counter or in the active duty register changes where the pin edges fall. This shows up on the pins within one period of period+1 cycles, and a late duty load shows up at the first wrap. A dead-band counter that is stuck or miscounts moves a half-bridge rising edge by at least one cycle in the very next pulse. A steering or polarity decode fault shows on pwm_out or pwm_oe in the first cycle after the enabling write. The sweeps compare every cycle against arithmetic expectations over all steering codes, all polarities, all duty values up to beyond the period, and several dead-band counts.

// File: rtl/epwm_steer.sv
module epwm_steer #(
  parameter int CNT_W = 10,
  parameter int DBW   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             duty_we,
  input  logic [CNT_W-3:0] duty_wdata,
  input  logic [CNT_W-1:0] period,
  input  logic [DBW-1:0]   dead_cnt,
  output logic [3:0]       pwm_out,
  output logic [3:0]       pwm_oe
);
  localparam int HI_W = CNT_W - 2;

  logic [3:0]       mode_q;
  logic [1:0]       steer_q, dlo_q;
  logic [HI_W-1:0]  dhi_q;
  logic [CNT_W-1:0] duty_act, cnt_q;
  logic [DBW-1:0]   run_a, run_b;
  logic [3:0]       act, oe, mask;

  wire on      = mode_q[3:2] == 2'b11;
  wire pwm_raw = on && (cnt_q < duty_act);
  wire pwm_cmp = on && !(cnt_q < duty_act);
  wire a_db    = pwm_raw && (run_a >= dead_cnt);
  wire b_db    = pwm_cmp && (run_b >= dead_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; steer_q <= '0; dlo_q <= '0; dhi_q <= '0;
      duty_act <= '0; cnt_q <= '0; run_a <= '0; run_b <= '0;
    end else begin
      if (ctl_we) {steer_q, dlo_q, mode_q} <= ctl_wdata;
      if (duty_we) dhi_q <= duty_wdata;
      if (!on || cnt_q >= period) begin
        cnt_q    <= '0;
        duty_act <= {dhi_q, dlo_q};
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (!pwm_raw) run_a <= '0;
      else if (run_a < dead_cnt) run_a <= run_a + 1'b1;
      if (!pwm_cmp) run_b <= '0;
      else if (run_b < dead_cnt) run_b <= run_b + 1'b1;
    end
  end

  always_comb begin
    case (steer_q)
      2'b00:   begin act = {3'b000, pwm_raw};          oe = 4'b0001; end
      2'b01:   begin act = {pwm_raw, 3'b001};          oe = 4'b1111; end
      2'b10:   begin act = {2'b00, b_db, a_db};        oe = 4'b0011; end
      default: begin act = {2'b01, pwm_raw, 1'b0};     oe = 4'b1111; end
    endcase
  end

  assign mask    = {mode_q[0], mode_q[1], mode_q[0], mode_q[1]};
  assign pwm_oe  = on ? oe : 4'b0000;
  assign pwm_out = on ? ((act ^ mask) & oe) : 4'b0000;
endmodule

// File: rtl/epwm_steer_chk.sv
module epwm_steer_chk #(
  parameter int CNT_W = 10,
  parameter int DBW   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic [3:0]       mode_q,
  input logic [1:0]       steer_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period,
  input logic [DBW-1:0]   dead_cnt,
  input logic             on,
  input logic             pwm_raw,
  input logic             a_db,
  input logic             b_db,
  input logic [3:0]       pwm_out,
  input logic [3:0]       pwm_oe
);
  a_r2_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[3:2] != 2'b11) |=> (pwm_oe == 4'b0000 && pwm_out == 4'b0000));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (on && cnt_q >= period) |=> (cnt_q == '0));

  a_r5_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (on && steer_q == 2'b00) |-> (pwm_oe == 4'b0001 && pwm_out[3:1] == 3'b000));

  a_r6_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on && steer_q == 2'b01) |-> (pwm_oe == 4'b1111 && pwm_out[0] == !mode_q[1]));

  a_r8_rev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on && steer_q == 2'b11) |-> (pwm_oe == 4'b1111 && pwm_out[2] == !mode_q[1]));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (on && steer_q == 2'b10) |-> !(a_db && b_db));

  a_r11_rise_late: assert property (@(posedge clk) disable iff (!rst_n)
    (on && steer_q == 2'b10 && dead_cnt != '0 && $rose(a_db)) |-> $past(pwm_raw));
endmodule

bind epwm_steer epwm_steer_chk #(.CNT_W(CNT_W), .DBW(DBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .mode_q(mode_q), .steer_q(steer_q), .cnt_q(cnt_q), .period(period),
  .dead_cnt(dead_cnt), .on(on), .pwm_raw(pwm_raw), .a_db(a_db), .b_db(b_db),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/epwm_steer_test.sv
module epwm_steer_test;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, duty_we = 0;
  logic [7:0] ctl_wdata = 0, duty_wdata = 0;
  logic [9:0] period = 0;
  logic [6:0] dead_cnt = 0;
  logic [3:0] pwm_out, pwm_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  epwm_steer uut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata), .period(period), .dead_cnt(dead_cnt),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  task automatic chk(string tag, logic [3:0] eo, logic [3:0] ee);
    checks++;
    if (pwm_out !== eo || pwm_oe !== ee) begin
      errors++;
      $display("FAIL %s out=%b oe=%b expected out=%b oe=%b", tag, pwm_out, pwm_oe, eo, ee);
    end
  endtask

  // expected pins from the requirements: A=bit0 .. D=bit3 (R10)
  function automatic logic [7:0] expect_pins(int st, int pol, bit p, bit ad, bit bd);
    logic [3:0] act, oe, m;
    case (st)
      0: begin act = {3'b000, p};   oe = 4'b0001; end // R5
      1: begin act = {p, 3'b001};   oe = 4'b1111; end // R6
      2: begin act = {2'b00, bd, ad}; oe = 4'b0011; end // R7
      default: begin act = {2'b01, p, 1'b0}; oe = 4'b1111; end // R8
    endcase
    m = {pol[0], pol[1], pol[0], pol[1]}; // R9
    return {(act ^ m) & oe, oe};
  endfunction

  // R1: ctl byte = {steer, duty low, mode}
  task automatic ctl(int st, int lo, int mode);
    @(negedge clk);
    ctl_wdata = 8'((st << 6) | (lo << 4) | mode);
    ctl_we = 1;
  endtask

  task automatic run_case(int st, int pol, int d, int p_last, int db, int ncyc,
                          int new_d, int wr_at);
    int ra = 0, rb = 0, dcur = d;
    @(negedge clk);
    ctl_we = 0; period = 10'(p_last); dead_cnt = 7'(db);
    duty_wdata = 8'(d >> 2); duty_we = 1;
    ctl(st, d & 3, 0);
    duty_we = 0;
    ctl(st, d & 3, 12 + pol);
    for (int k = 0; k < ncyc; k++) begin
      bit p, n, ad, bd;
      logic [7:0] e;
      int c;
      @(negedge clk);
      ctl_we = 0; duty_we = 0;
      c = k % (p_last + 1);
      if (wr_at >= 0 && c == 0 && k > wr_at) dcur = new_d; // R4
      p = c < dcur;                                    // R3
      n = !p;
      ad = p && ra >= db;                              // R11
      bd = n && rb >= db;
      e = expect_pins(st, pol, p, ad, bd);
      case (st)
        0: chk("R5 R3 R9 R1", e[7:4], e[3:0]);
        1: chk("R6 R3 R9", e[7:4], e[3:0]);
        2: chk("R7 R11 R9", e[7:4], e[3:0]);
        default: chk("R8 R3 R9", e[7:4], e[3:0]);
      endcase
      if (wr_at >= 0 && k == wr_at) begin
        duty_wdata = 8'(new_d >> 2); duty_we = 1;       // R4 mid-period write
      end
      ra = p ? (ra < db ? ra + 1 : ra) : 0;
      rb = n ? (rb < db ? rb + 1 : rb) : 0;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 R10 reset", 4'b0000, 4'b0000);
    rst_n = 1;
    // R3 R5 R6 R7 R8 R9: sweep steering, polarity and duty (duty 6,7 exceed period 5)
    for (int st = 0; st < 4; st++)
      for (int pol = 0; pol < 4; pol++)
        for (int d = 0; d < 8; d++)
          run_case(st, pol, d, 5, 2, 14, 0, -1);
    // R11: dead-band sweep in half-bridge
    for (int db = 0; db < 5; db++)
      for (int d = 0; d < 10; d++)
        run_case(2, db & 3, d, 6, db, 16, 0, -1);
    // R4: mid-period duty update applies at the wrap only
    run_case(0, 0, 2, 7, 0, 24, 6, 3);
    run_case(1, 2, 5, 7, 0, 24, 1, 4);
    // R2 R10: mode 0000 and a non-PWM mode release every pin
    run_case(2, 0, 3, 5, 1, 4, 0, -1);
    ctl(2, 3, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ctl_we = 0;
      chk("R2 R10 mode off", 4'b0000, 4'b0000);
    end
    ctl(3, 0, 8);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ctl_we = 0;
      chk("R2 non-PWM mode", 4'b0000, 4'b0000);
    end
    // R2: counter restarts from zero after re-enable
    run_case(0, 0, 3, 5, 0, 8, 0, -1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule